// File: doc/BRIEF.md
# Word/Byte Subtractor with Status Flags

This block is the subtract path of a 16-bit processor datapath. It receives a source and a destination operand, a byte-mode select and the current status bits. It returns the difference, destination minus source, and a fresh set of overflow, negative, zero and carry flags. The unit is purely combinational, so its outputs follow its inputs with no clock.

In word mode the block works on all sixteen bits. In byte mode it looks only at the low eight bits of each operand, returns the difference zero-extended to sixteen bits, and takes every flag from the eight-bit operation. Carry means no borrow occurred. The incoming status bits never affect the arithmetic. They are passed through unchanged beside the new flags, so the surrounding datapath decides which set to write back.

Top module: `word_sub_unit`

## Requirements
- R1: In word mode (`byte_mode_i`=0), `diff_o` equals (`dst_i` - `src_i`) modulo 2^16.
- R2: `status_i` has no effect on `diff_o` or `flags_o`, including its carry bit (bit 0). `status_o` always equals `status_i`.
- R3: In byte mode (`byte_mode_i`=1), only bits 7:0 of each operand are used, `diff_o[7:0]` equals (`dst_i[7:0]` - `src_i[7:0]`) modulo 256, and `diff_o[15:8]` is zero.
- R4: Carry (`flags_o[0]`) is 1 exactly when the selected-width destination is greater than or equal to the selected-width source as unsigned numbers, meaning no borrow occurred.
- R5: Zero (`flags_o[1]`) is 1 exactly when the selected-width difference is all zeros.
- R6: Negative (`flags_o[2]`) equals the top bit of the selected-width difference: bit 15 in word mode, bit 7 in byte mode.
- R7: Overflow (`flags_o[3]`) is 1 exactly when the operands have opposite signs at the selected width and the sign of the difference differs from the sign of the destination. This is the case where the true signed difference does not fit in the selected width.
- R8: `flags_o` is packed as {V, N, Z, C} from bit 3 down to bit 0. For example, word 0x7FF0 - 0x80FF gives `diff_o`=0xFEF1 and `flags_o`=4'b1100.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_i | input | 16 | Source operand (subtrahend) |
| dst_i | input | 16 | Destination operand (minuend) |
| byte_mode_i | input | 1 | 1 selects the 8-bit operation, 0 the 16-bit operation |
| status_i | input | 4 | Current status bits {V, N, Z, C} |
| diff_o | output | 16 | Difference, zero-extended in byte mode |
| flags_o | output | 4 | New flags {V, N, Z, C} |
| status_o | output | 4 | `status_i` passed through unchanged |

## Verification
The unit contains no register, so every result is due in the same cycle its operands are applied. There are zero clock edges between stimulus and response. The bench changes the inputs on the falling edge of its clock and samples all three outputs two nanoseconds later, before the next rising edge. Each check therefore sees settled values for exactly one operand set. The stimulus combines directed vectors and seeded random operands, and each random check is compared against a bench model that computes overflow through signed range checking rather than through sign-bit logic.

// File: rtl/subu_pkg.sv
package subu_pkg;

  localparam int unsigned WORD_W = 16;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned FLAG_W = 4;

  // flag positions inside the packed {V,N,Z,C} vector
  localparam int unsigned FLG_C = 0;
  localparam int unsigned FLG_Z = 1;
  localparam int unsigned FLG_N = 2;
  localparam int unsigned FLG_V = 3;

  typedef struct packed {
    logic v;
    logic n;
    logic z;
    logic c;
  } subu_flags_t;

  // signed overflow of a-b: operand signs differ and result sign left a's sign
  function automatic logic sub_ovf(input logic a_msb, input logic b_msb,
                                   input logic r_msb);
    return (a_msb ^ b_msb) & (a_msb ^ r_msb);
  endfunction

  // one bit of a ripple subtractor: a - b with incoming no-borrow cin
  function automatic logic [1:0] sub_bit(input logic a, input logic b,
                                         input logic cin);
    logic nb;
    nb = ~b;
    return {(a & nb) | (cin & (a ^ nb)), a ^ nb ^ cin};
  endfunction

endpackage

// File: rtl/subu_operand_sel.sv
module subu_operand_sel #(
  parameter int unsigned DATA_W = subu_pkg::WORD_W,
  parameter int unsigned NARROW_W = subu_pkg::LANE_W
) (
  input  logic [DATA_W-1:0] raw_i,
  input  logic              narrow_i,
  output logic [DATA_W-1:0] sel_o
);

  // low lane always passes; upper bits are cleared in narrow mode
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i < NARROW_W) begin : g_low
      assign sel_o[i] = raw_i[i];
    end else begin : g_high
      assign sel_o[i] = raw_i[i] & ~narrow_i;
    end
  end

endmodule

// File: rtl/subu_ripple.sv
module subu_ripple #(
  parameter int unsigned DATA_W = subu_pkg::WORD_W
) (
  input  logic [DATA_W-1:0] min_i,
  input  logic [DATA_W-1:0] sub_i,
  output logic [DATA_W-1:0] diff_o,
  output logic [DATA_W:0]   nobrw_o
);

  // nobrw_o[k] is the no-borrow into bit k; nobrw_o[DATA_W] is the carry out
  assign nobrw_o[0] = 1'b1;

  for (genvar i = 0; i < DATA_W; i++) begin : g_stage
    logic [1:0] step;
    assign step         = subu_pkg::sub_bit(min_i[i], sub_i[i], nobrw_o[i]);
    assign diff_o[i]    = step[0];
    assign nobrw_o[i+1] = step[1];
  end

endmodule

// File: rtl/subu_flag_gen.sv
module subu_flag_gen #(
  parameter int unsigned DATA_W = subu_pkg::WORD_W,
  parameter int unsigned NARROW_W = subu_pkg::LANE_W
) (
  input  logic [DATA_W-1:0]        dst_sel_i,
  input  logic [DATA_W-1:0]        src_sel_i,
  input  logic [DATA_W-1:0]        raw_diff_i,
  input  logic [DATA_W:0]          nobrw_i,
  input  logic                     narrow_i,
  output logic [DATA_W-1:0]        diff_o,
  output subu_pkg::subu_flags_t    flags_o
);

  localparam int unsigned TOP_W = DATA_W - 1;
  localparam int unsigned TOP_N = NARROW_W - 1;

  logic [DATA_W-1:0] width_mask;
  logic              dst_msb, src_msb, res_msb;
  logic              carry_out;

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    if (i < NARROW_W) begin : g_in
      assign width_mask[i] = 1'b1;
    end else begin : g_out
      assign width_mask[i] = ~narrow_i;
    end
  end

  assign diff_o    = raw_diff_i & width_mask;
  assign dst_msb   = narrow_i ? dst_sel_i[TOP_N]  : dst_sel_i[TOP_W];
  assign src_msb   = narrow_i ? src_sel_i[TOP_N]  : src_sel_i[TOP_W];
  assign res_msb   = narrow_i ? raw_diff_i[TOP_N] : raw_diff_i[TOP_W];
  assign carry_out = narrow_i ? nobrw_i[NARROW_W] : nobrw_i[DATA_W];

  assign flags_o.c = carry_out;
  assign flags_o.z = ~|diff_o;
  assign flags_o.n = res_msb;
  assign flags_o.v = subu_pkg::sub_ovf(dst_msb, src_msb, res_msb);

  always_comb begin
    if (!$isunknown({dst_sel_i, src_sel_i, narrow_i})) begin
      AST_CARRY_NO_BORROW: assert (flags_o.c == (dst_sel_i >= src_sel_i)) else $error("carry mismatch"); // R4
      AST_OVF_NEEDS_SIGN_SPLIT: assert (!flags_o.v || (dst_msb != src_msb)) else $error("overflow with like signs"); // R7
    end
  end

endmodule

// File: rtl/word_sub_unit.sv
module word_sub_unit #(
  parameter int unsigned DATA_W = subu_pkg::WORD_W,
  parameter int unsigned NARROW_W = subu_pkg::LANE_W,
  parameter int unsigned FLAG_W = subu_pkg::FLAG_W
) (
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic              byte_mode_i,
  input  logic [FLAG_W-1:0] status_i,
  output logic [DATA_W-1:0] diff_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic [FLAG_W-1:0] status_o
);

  localparam int unsigned HIGH_W = DATA_W - NARROW_W;

  logic [DATA_W-1:0]     dst_sel, src_sel, raw_diff;
  logic [DATA_W:0]       nobrw;
  subu_pkg::subu_flags_t flags_s;

  subu_operand_sel #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_dst_sel (
    .raw_i(dst_i), .narrow_i(byte_mode_i), .sel_o(dst_sel)
  );

  subu_operand_sel #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_src_sel (
    .raw_i(src_i), .narrow_i(byte_mode_i), .sel_o(src_sel)
  );

  subu_ripple #(.DATA_W(DATA_W)) u_ripple (
    .min_i(dst_sel), .sub_i(src_sel), .diff_o(raw_diff), .nobrw_o(nobrw)
  );

  subu_flag_gen #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_flags (
    .dst_sel_i(dst_sel), .src_sel_i(src_sel), .raw_diff_i(raw_diff),
    .nobrw_i(nobrw), .narrow_i(byte_mode_i), .diff_o(diff_o), .flags_o(flags_s)
  );

  assign flags_o  = flags_s;
  assign status_o = status_i;

  always_comb begin
    if (!$isunknown({dst_i, src_i, byte_mode_i})) begin
      AST_DIFF_ADDS_BACK: assert (DATA_W'(diff_o + src_sel) == dst_sel || byte_mode_i) else $error("word difference wrong"); // R1
      AST_BYTE_UPPER_CLEAR: assert (!byte_mode_i || diff_o[DATA_W-1 -: HIGH_W] == '0) else $error("byte upper not zero"); // R3
      AST_ZERO_MATCH: assert (flags_o[subu_pkg::FLG_Z] == (diff_o == '0)) else $error("zero flag mismatch"); // R5
      AST_NEG_TOP_BIT: assert (flags_o[subu_pkg::FLG_N] == (byte_mode_i ? diff_o[NARROW_W-1] : diff_o[DATA_W-1])) else $error("negative flag mismatch"); // R6
    end
  end

endmodule

// File: tb/sim_word_sub_unit.sv
`timescale 1ns/100ps
module sim_word_sub_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] src, dst, diff;
  logic        bm;
  logic [3:0]  st, flags, st_out;
  int          n_checks = 0;
  int          n_errors = 0;
  int          cyc = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  word_sub_unit u0 (
    .src_i(src), .dst_i(dst), .byte_mode_i(bm), .status_i(st),
    .diff_o(diff), .flags_o(flags), .status_o(st_out)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // bench model: {V,N,Z,C, diff}, overflow from signed range
  function automatic logic [19:0] model(input logic [15:0] d, input logic [15:0] s,
                                        input bit byte_m);
    int w, mask, half, dd, ss, r, sd, sv, full;
    logic v, n, z, c;
    w    = byte_m ? 8 : 16;
    mask = (1 << w) - 1;
    half = 1 << (w - 1);
    dd   = int'(d) & mask;
    ss   = int'(s) & mask;
    r    = (dd - ss) & mask;
    sd   = (dd >= half) ? dd - (2 * half) : dd;
    sv   = (ss >= half) ? ss - (2 * half) : ss;
    full = sd - sv;
    v = (full < -half) || (full >= half);
    n = (r >= half);
    z = (r == 0);
    c = (dd >= ss);
    return {v, n, z, c, 16'(r)};
  endfunction

  task automatic drive(input logic [15:0] d, input logic [15:0] s, input bit b,
                       input logic [3:0] stat);
    @(negedge clk);
    dst = d; src = s; bm = b; st = stat;
    #2;
  endtask

  task automatic directed(input logic [15:0] d, input logic [15:0] s, input bit b,
                          input logic [3:0] stat, input logic [15:0] ed,
                          input logic [3:0] ef);
    drive(d, s, b, stat);
    check(diff == ed, b ? "R3" : "R1", "directed diff", diff, ed);
    check(flags == ef, "R8", "directed flag vector", 16'(flags), 16'(ef));
    check(st_out == stat, "R2", "status pass", 16'(st_out), 16'(stat));
  endtask

  task automatic random_one(input bit b);
    logic [15:0] d, s;
    logic [3:0]  stat;
    logic [19:0] e;
    logic [15:0] d0;
    logic [3:0]  f0;
    d = 16'($urandom); s = 16'($urandom); stat = 4'($urandom);
    if (($urandom % 8) == 0) s = d ^ (b ? 16'hFF00 : 16'h0000);  // equal lanes
    e = model(d, s, b);
    drive(d, s, b, stat);
    check(diff == e[15:0], b ? "R3" : "R1", "diff", diff, e[15:0]);
    check(flags[0] == e[16], "R4", "carry", 16'(flags[0]), 16'(e[16]));
    check(flags[1] == e[17], "R5", "zero", 16'(flags[1]), 16'(e[17]));
    check(flags[2] == e[18], "R6", "negative", 16'(flags[2]), 16'(e[18]));
    check(flags[3] == e[19], "R7", "overflow", 16'(flags[3]), 16'(e[19]));
    d0 = diff; f0 = flags;
    drive(d, s, b, ~stat);  // R2: flipped status must not change results
    check(diff == d0 && flags == f0, "R2", "status influence",
          {diff[11:0], flags}, {d0[11:0], f0});
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=%0d expected<100000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    dst = '0; src = '0; bm = 1'b0; st = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #1;
    // reset state: zero operands give zero result, Z and C set
    check(diff == 16'h0000, "R1", "reset diff", diff, 16'h0000);
    check(flags == 4'b0011, "R8", "reset flags", 16'(flags), 16'h0003);

    // word vectors
    directed(16'h8888, 16'h3333, 1'b0, 4'h0, 16'h5555, 4'b1001);
    directed(16'h9999, 16'h5555, 1'b0, 4'h1, 16'h4444, 4'b1001);  // R2 carry in
    directed(16'h0666, 16'h0AAA, 1'b0, 4'h0, 16'hFBBC, 4'b0100);
    directed(16'h0555, 16'h0444, 1'b0, 4'h0, 16'h0111, 4'b0001);
    directed(16'h0333, 16'h0333, 1'b0, 4'h0, 16'h0000, 4'b0011);
    directed(16'h7FF0, 16'h80FF, 1'b0, 4'h0, 16'hFEF1, 4'b1100);
    directed(16'h8000, 16'h7F00, 1'b0, 4'h0, 16'h0100, 4'b1001);
    // byte vectors (R3: upper bytes ignored)
    directed(16'h8888, 16'h3333, 1'b1, 4'h0, 16'h0055, 4'b1001);
    directed(16'h9999, 16'h5555, 1'b1, 4'h1, 16'h0044, 4'b1001);
    directed(16'h5106, 16'h890A, 1'b1, 4'h0, 16'h00FC, 4'b0100);
    directed(16'h5305, 16'hFA04, 1'b1, 4'h0, 16'h0001, 4'b0001);
    directed(16'h8A03, 16'hE603, 1'b1, 4'h0, 16'h0000, 4'b0011);
    directed(16'h817F, 16'h7387, 1'b1, 4'h0, 16'h00F8, 4'b1100);
    directed(16'h5480, 16'h8175, 1'b1, 4'h0, 16'h000B, 4'b1001);
    // corner: upper bytes differ only, byte mode must report zero
    directed(16'hFF00, 16'h0000, 1'b1, 4'hF, 16'h0000, 4'b0011);
    directed(16'h0000, 16'h0001, 1'b0, 4'hF, 16'hFFFF, 4'b0100);

    for (int i = 0; i < 300; i++) random_one(1'b0);
    for (int i = 0; i < 300; i++) random_one(1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule